// File: doc/BRIEF.md
# Windowed Watchdog Timer with Early Warning

This block is a supervision timer that runs from the system bus clock. A programmable prescaler divides that clock to produce a count tick. A 7-bit down-counter loses one on each tick. Software must refresh the counter within a time window. A refresh is legal only once the counter has fallen to or below a programmable window value, and it must arrive before the counter runs out. A refresh that comes too soon asserts a reset request, and so does a counter that runs out. The window therefore catches code that loops too fast as well as code that has stalled.

Software configures the block through a small write-only register port with four locations: control, window, reload and kick. After software writes the enable bit, no later write can clear it. Before a timeout, a sticky warning interrupt gives software time to save diagnostic state. Every reset request is a single-cycle pulse, and on the same edge the block puts itself back into its power-on state.

Top module: `win_watchdog`

## Requirements
- R1: After reset, count_o reads 127, rst_req and warn_irq are 0, and the block is disabled, so the count does not move.
- R2: The control register at address 0 holds the prescaler select in data bits [2:1]. When the select code is s, an enabled counter decrements once every 2^s clock cycles.
- R3: Writing 1 to control bit 0 enables the block. A later control write with bit 0 at 0 does not disable it, and counting carries on.
- R4: A kick write has address 3 and data bit 0 set. If it arrives while the block is enabled and the count is at or below the window register (address 1), the count is loaded from the reload register (address 2) on the next edge, and no reset is requested.
- R5: A kick write that arrives while the count is above the window value makes rst_req high in the following cycle.
- R6: If a tick arrives while the count is 0 and no kick arrives in that cycle, rst_req goes high in the following cycle.
- R7: rst_req is high for exactly one cycle. In that cycle the block is back in its power-on state: disabled, count 127, warn_irq clear, window and reload at 127, and prescaler select 0.
- R8: warn_irq is set on the first edge at which the block is enabled with a count of 1, and it stays set afterwards.
- R9: A kick-address write with data bit 1 set clears warn_irq. If the set condition of R8 holds on the same edge, the flag stays set.
- R10: When the window value is at least the reload value, every kick after the first legal one is also legal.
- R11: A kick while the block is disabled has no effect: no reset request, and the count is unchanged.
- R12: A kick that arrives on the same edge as an expiring tick at count 0 is accepted. The count reloads and no reset is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 control, 1 window, 2 reload, 3 kick |
| wr_data | input | 7 | Write data |
| count_o | output | 7 | Current counter value |
| warn_irq | output | 1 | Sticky early-warning interrupt |
| rst_req | output | 1 | Single-cycle reset request |

## Verification
On every cycle the assertions check the following: that reset pulses last one cycle; that the block is in its power-on state during a pulse; that early and expired refreshes lead to a pulse; that legal refreshes reload the count; that the count holds between ticks; that the enable bit falls only with a pulse; and that the warning flag falls only after a clear write or a pulse. Some behaviours can be shown only by the bench's scenarios, checked against a cycle-level reference model: the tick spacing for each divide code, the exact cycle when a refresh falls into the window, the set-over-clear collision, the permissive window above the reload value, and a refresh that lands exactly on the expiring tick.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  // Register map; the kick location carries the refresh and clear bits.
  typedef enum logic [1:0] {
    REG_CTRL   = 2'd0,
    REG_WIN    = 2'd1,
    REG_RELOAD = 2'd2,
    REG_KICK   = 2'd3
  } wdt_reg_e;

  localparam int unsigned KICK_REFRESH_BIT = 0;
  localparam int unsigned KICK_CLEAR_BIT   = 1;
  localparam int unsigned CTRL_EN_BIT      = 0;
  localparam int unsigned CTRL_SEL_LSB     = 1;
endpackage

// File: rtl/wdt_rst_sync.sv
module wdt_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_s = sync_q[1];
endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int unsigned SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int unsigned DIV_W = (1 << SEL_W) - 1;

  logic [DIV_W-1:0] div_q, div_d;
  logic [DIV_W:0]   one_hot;
  logic [DIV_W-1:0] mask;

  always_comb begin
    one_hot = (DIV_W+1)'(1) << sel;
    mask    = one_hot[DIV_W-1:0] - DIV_W'(1);
    tick    = run && ((div_q & mask) == mask);
    if (!run || restart) div_d = '0;
    else                 div_d = div_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int unsigned CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             tick,
  input  logic             refresh,
  input  logic [CNT_W-1:0] win,
  input  logic [CNT_W-1:0] rel,
  output logic [CNT_W-1:0] cnt,
  output logic             refresh_ok,
  output logic             trip,
  output logic             at_one
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             early, expire;

  always_comb begin
    early      = refresh && (cnt_q > win);
    refresh_ok = refresh && !early;
    expire     = en && tick && (cnt_q == '0) && !refresh;
    trip       = early || expire;
    at_one     = en && (cnt_q == CNT_W'(1));
    if (trip)            cnt_d = CNT_MAX;
    else if (refresh_ok) cnt_d = rel;
    else if (en && tick) cnt_d = cnt_q - CNT_W'(1);
    else                 cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= CNT_MAX;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/wdt_warn.sv
module wdt_warn (
  input  logic clk,
  input  logic rst_n,
  input  logic at_one,
  input  logic clear,
  input  logic trip,
  output logic flag
);
  logic flag_q, flag_d;

  always_comb begin
    if (trip)        flag_d = 1'b0;
    else if (at_one) flag_d = 1'b1;
    else if (clear)  flag_d = 1'b0;
    else             flag_d = flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag = flag_q;
endmodule

// File: rtl/win_watchdog.sv
module win_watchdog #(
  parameter int unsigned CNT_W = 7,
  parameter int unsigned SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] count_o,
  output logic             warn_irq,
  output logic             rst_req
);
  import wdt_pkg::*;

  localparam logic [CNT_W-1:0] CFG_MAX = '1;

  logic             rst_n_s;
  logic             en_q, en_d;
  logic [SEL_W-1:0] sel_q, sel_d;
  logic [CNT_W-1:0] win_q, win_d, rel_q, rel_d;
  logic             rst_req_q;
  logic             tick, refresh, refresh_ok, trip, at_one, clr_wr;
  logic             ctrl_wr, win_wr, rel_wr, kick_wr;
  logic [CNT_W-1:0] cnt_q;

  wdt_rst_sync u_rst_sync (.clk(clk), .rst_n(rst_n), .rst_n_s(rst_n_s));

  always_comb begin
    ctrl_wr = wr_en && (wr_addr == REG_CTRL);
    win_wr  = wr_en && (wr_addr == REG_WIN);
    rel_wr  = wr_en && (wr_addr == REG_RELOAD);
    kick_wr = wr_en && (wr_addr == REG_KICK);
    refresh = kick_wr && wr_data[KICK_REFRESH_BIT] && en_q;
    clr_wr  = kick_wr && wr_data[KICK_CLEAR_BIT];
  end

  wdt_prescaler #(.SEL_W(SEL_W)) u_pre (
    .clk(clk), .rst_n(rst_n_s), .run(en_q),
    .restart(refresh_ok || trip), .sel(sel_q), .tick(tick)
  );

  wdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n_s), .en(en_q), .tick(tick), .refresh(refresh),
    .win(win_q), .rel(rel_q), .cnt(cnt_q), .refresh_ok(refresh_ok),
    .trip(trip), .at_one(at_one)
  );

  wdt_warn u_warn (
    .clk(clk), .rst_n(rst_n_s), .at_one(at_one), .clear(clr_wr),
    .trip(trip), .flag(warn_irq)
  );

  // Configuration next state: a trip restores power-on values.
  always_comb begin
    en_d  = en_q;
    sel_d = sel_q;
    win_d = win_q;
    rel_d = rel_q;
    if (trip) begin
      en_d  = 1'b0;
      sel_d = '0;
      win_d = CFG_MAX;
      rel_d = CFG_MAX;
    end else begin
      if (ctrl_wr) begin
        en_d  = en_q | wr_data[CTRL_EN_BIT];
        sel_d = wr_data[CTRL_SEL_LSB +: SEL_W];
      end
      if (win_wr) win_d = wr_data;
      if (rel_wr) rel_d = wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      en_q      <= 1'b0;
      sel_q     <= '0;
      win_q     <= CFG_MAX;
      rel_q     <= CFG_MAX;
      rst_req_q <= 1'b0;
    end else begin
      en_q      <= en_d;
      sel_q     <= sel_d;
      win_q     <= win_d;
      rel_q     <= rel_d;
      rst_req_q <= trip;
    end
  end

  assign count_o = cnt_q;
  assign rst_req = rst_req_q;
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker #(
  parameter int unsigned CNT_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             tick,
  input logic             refresh,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] win,
  input logic [CNT_W-1:0] rel,
  input logic             clr_wr,
  input logic             rst_req,
  input logic             warn
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);

  a_r7_power_on_state: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> (cnt == CMAX) && !warn && !en);

  a_r5_early_trips: assert property (@(posedge clk) disable iff (!rst_n)
    (refresh && (cnt > win)) |=> rst_req);

  a_r6_expiry_trips: assert property (@(posedge clk) disable iff (!rst_n)
    (en && tick && (cnt == '0) && !refresh) |=> rst_req);

  a_r4_legal_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (refresh && (cnt <= win)) |=> (cnt == $past(rel)) && !rst_req);

  a_r2_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !refresh && !tick) |=> $stable(cnt));

  a_r8_warn_set: assert property (@(posedge clk) disable iff (!rst_n)
    (en && (cnt == CNT_W'(1))) |=> warn || rst_req);

  a_r9_warn_falls_only_on_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(warn) |-> rst_req || $past(clr_wr));

  a_r3_enable_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en) |-> rst_req);
endmodule

bind win_watchdog wdt_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n_s), .en(en_q), .tick(tick), .refresh(refresh),
  .cnt(cnt_q), .win(win_q), .rel(rel_q), .clr_wr(clr_wr),
  .rst_req(rst_req), .warn(warn_irq)
);

// File: tb/win_watchdog_test.sv
`timescale 1ns/1ps
module win_watchdog_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [1:0] wr_addr;
  logic [6:0] wr_data;
  logic [6:0] count_o;
  logic       warn_irq, rst_req;

  int checks = 0;
  int fails  = 0;
  string cur_req = "R1";

  // Behavioural reference state
  int m_en, m_sel, m_win, m_rel, m_cnt, m_phase, m_flag, m_rst;

  always #2.5 clk = ~clk;

  win_watchdog uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .count_o(count_o), .warn_irq(warn_irq), .rst_req(rst_req)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_en = 0; m_sel = 0; m_win = 127; m_rel = 127;
    m_cnt = 127; m_phase = 0; m_flag = 0; m_rst = 0;
  endtask

  initial model_reset();

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else begin
      int period;
      bit tk, kick, clr, ref_ok, early, expd;
      period = 1 << m_sel;
      tk     = (m_en != 0) && ((m_phase % period) == period - 1);
      kick   = wr_en && wr_addr == 2'd3 && wr_data[0];
      clr    = wr_en && wr_addr == 2'd3 && wr_data[1];
      early  = kick && (m_en != 0) && (m_cnt > m_win);
      ref_ok = kick && (m_en != 0) && !early;
      expd   = tk && (m_cnt == 0) && !kick;
      if (early || expd) begin
        model_reset();
        m_rst = 1;
      end else begin
        m_rst = 0;
        if (m_en != 0 && m_cnt == 1) m_flag = 1;
        else if (clr) m_flag = 0;
        if (ref_ok) m_cnt = m_rel;
        else if (tk) m_cnt = m_cnt - 1;
        if (m_en == 0 || ref_ok) m_phase = 0;
        else m_phase = m_phase + 1;
        if (wr_en && wr_addr == 2'd0) begin
          if (wr_data[0]) m_en = 1;
          m_sel = int'(wr_data[2:1]);
        end
        if (wr_en && wr_addr == 2'd1) m_win = int'(wr_data);
        if (wr_en && wr_addr == 2'd2) m_rel = int'(wr_data);
      end
    end
  end

  // Compare against the reference on every clock, away from the edge.
  always @(negedge clk) begin
    if (rst_n) begin
      check(cur_req, int'(count_o), m_cnt);
      check(cur_req, int'(rst_req), m_rst);
      check(cur_req, int'(warn_irq), m_flag);
    end
  end

  // Called at a negedge; returns at the next negedge.
  task automatic wr(input logic [1:0] a, input logic [6:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_addr = 2'd0; wr_data = 7'd0;
  endtask

  task automatic wait_count(input int v);
    while (int'(count_o) != v) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = 2'd0; wr_data = 7'd0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: power-on state, idle counter
    cur_req = "R1";
    check("R1", int'(count_o), 127);
    check("R1", int'(rst_req), 0);
    check("R1", int'(warn_irq), 0);
    repeat (10) @(negedge clk);
    check("R1", int'(count_o), 127);

    // R11: kick while disabled
    cur_req = "R11";
    wr(2'd3, 7'h01);
    check("R11", int'(rst_req), 0);
    @(negedge clk);
    check("R11", int'(rst_req), 0);
    check("R11", int'(count_o), 127);

    // R5 / R7: early kick
    cur_req = "R5";
    wr(2'd1, 7'd40); wr(2'd2, 7'd60); wr(2'd0, 7'h01);
    wait_count(100);
    wr(2'd3, 7'h01);
    check("R5", int'(rst_req), 1);
    check("R7", int'(count_o), 127);
    @(negedge clk);
    check("R7", int'(rst_req), 0);
    repeat (5) @(negedge clk);
    check("R7", int'(count_o), 127);

    // R4: legal kick inside the window
    cur_req = "R4";
    wr(2'd1, 7'd40); wr(2'd2, 7'd60); wr(2'd0, 7'h01);
    wait_count(30);
    wr(2'd3, 7'h01);
    check("R4", int'(count_o), 60);
    check("R4", int'(rst_req), 0);

    // R3: enable cannot be cleared by software
    cur_req = "R3";
    wr(2'd0, 7'h00);
    repeat (3) @(negedge clk);
    check("R3", int'(count_o), 56);

    // R8 / R6: warning one tick ahead, then expiry
    cur_req = "R8";
    wait_count(1);
    check("R8", int'(warn_irq), 0);
    @(negedge clk);
    check("R8", int'(warn_irq), 1);
    check("R8", int'(count_o), 0);
    cur_req = "R6";
    @(negedge clk);
    check("R6", int'(rst_req), 1);
    check("R7", int'(warn_irq), 0);
    check("R7", int'(count_o), 127);

    // R2: divide by 4 (select code 2 in bits [2:1])
    cur_req = "R2";
    wr(2'd0, 7'b0000101);
    wait_count(120);
    repeat (3) @(negedge clk);
    check("R2", int'(count_o), 120);
    @(negedge clk);
    check("R2", int'(count_o), 119);

    // R9: clear while set condition holds, then clear with a kick
    cur_req = "R9";
    wait_count(1);
    repeat (2) @(negedge clk);
    check("R8", int'(warn_irq), 1);
    wr(2'd3, 7'b0000010);
    check("R9", int'(warn_irq), 1);
    wait_count(0);
    wr(2'd3, 7'b0000011);
    check("R9", int'(warn_irq), 0);
    check("R4", int'(count_o), 127);
    check("R4", int'(rst_req), 0);

    // R10: window above reload makes repeated kicks legal
    cur_req = "R10";
    wr(2'd0, 7'h01);
    wr(2'd1, 7'd100); wr(2'd2, 7'd50);
    wait_count(100);
    wr(2'd3, 7'h01);
    check("R10", int'(count_o), 50);
    wr(2'd3, 7'h01);
    check("R10", int'(count_o), 50);
    check("R10", int'(rst_req), 0);

    // R12: kick on the expiring tick is accepted
    cur_req = "R12";
    wait_count(0);
    wr(2'd3, 7'h01);
    check("R12", int'(count_o), 50);
    check("R12", int'(rst_req), 0);
    @(negedge clk);
    check("R12", int'(rst_req), 0);

    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule